// File: doc/BRIEF.md
# Frame-Sync Serial Master

This block is a master-only serial port that uses the frame-sync style of framing. It does not hold a select line low for the whole word. Instead it raises a frame strobe for one serial-clock period, and the most significant data bit follows on the next rising clock edge.

Software-side logic pushes words into an 8-entry transmit queue and pops assembled words from an 8-entry receive queue. The serial clock is derived from the system clock through an even prescaler and a rate divider. Words may be 4 to 16 bits long. While the transmit queue keeps supplying data, frames run back to back with no idle time between them. When no frame is running, the serial clock and the strobe rest low and the data output floats.

Top module: `tifs_master`

## Requirements
- R1: While no frame is in progress, `sclk` and `fsync` are low and `dx_oe` is low (`dx` at high impedance).
- R2: With `enable` high and the transmit queue not empty, a frame starts. `fsync` rises together with a rising `sclk` edge and stays high for exactly one serial-clock period.
- R3: On the rising `sclk` edge that ends the strobe period, the word's MSB appears on `dx`. The remaining bits follow MSB first, one per period, and `dx` changes only on rising `sclk` edges. The frame length is `cfg_len_m1`+1 bits, and field values below 3 act as 3 (4-bit frames).
- R4: `dr` is sampled on falling `sclk` edges, MSB first. The received word is right-justified and zero-extended to 16 bits, and it enters the receive queue after the frame's last bit.
- R5: One serial-clock period lasts P×(`cfg_rate`+1) system clocks. P is `cfg_prescale` with bit 0 cleared, and a result of 0 is taken as 2.
- R6: If the transmit queue holds a word when the last bit of a frame begins, the next strobe is raised during that last-bit period. The next MSB then follows immediately, with no idle period.
- R7: The transmit queue holds 8 words. A write while it is full is dropped. `st_tx_empty` and `st_tx_not_full` report its state, and a write into an empty queue clears `st_tx_empty` on the next cycle.
- R8: The receive queue holds 8 words, and `rd_data` shows the oldest one. `rd_en` removes it. A frame completed while the queue is full is discarded, so `st_rx_full` and the stored words stay as they were.
- R9: While `enable` is low, no new frame starts and queued words are kept.
- R10: After reset, both queues are empty, `st_busy` is low and the serial outputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to start |
| cfg_len_m1 | input | 4 | Frame length minus one (3..15) |
| cfg_prescale | input | 8 | Even clock prescale value |
| cfg_rate | input | 8 | Rate divider value |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 16 | Word to transmit, right-justified |
| rd_en | input | 1 | Pop the oldest received word |
| rd_data | output | 16 | Oldest received word |
| st_tx_empty | output | 1 | Transmit queue empty |
| st_tx_not_full | output | 1 | Transmit queue has room |
| st_rx_not_empty | output | 1 | Receive queue holds a word |
| st_rx_full | output | 1 | Receive queue full |
| st_busy | output | 1 | A frame is in progress |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame strobe |
| dx | output | 1 | Serial data out, high impedance when idle |
| dx_oe | output | 1 | Drive enable of `dx` |
| dr | input | 1 | Serial data in |

## Verification
Several properties are checked on every cycle: the quiet idle pins, the strobe rising only with a rising clock edge and changing only on internal rising ticks, `dx` changing only after a rising tick, and the queue flag behaviour around writes and a full receive queue. Other behaviours can only be shown by the bench's scenarios with a slave model on the pins. These are the bit order and masking of each frame length, the exact period and strobe width for each prescale and rate pair, the absence of a gap in back-to-back runs, and which word is dropped when a queue overflows.

// File: rtl/tifs_pkg.sv
package tifs_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_DATA} tifs_state_e;

  // Frame length minus one, with values below 3 lifted to 3.
  function automatic logic [3:0] eff_len_m1(input logic [3:0] req);
    return (req < 4'd3) ? 4'd3 : req;
  endfunction

  // Half of one serial period, in system clocks.
  function automatic logic [15:0] half_period(input logic [7:0] pre, input logic [7:0] rate);
    logic [15:0] h;
    h = {9'd0, pre[7:1]};
    if (h == 16'd0) h = 16'd1;
    return h * ({8'd0, rate} + 16'd1);
  endfunction

  // Low (lm1+1) bits set.
  function automatic logic [WORD_W-1:0] word_mask(input logic [3:0] lm1);
    logic [16:0] m;
    m = (17'd2 << lm1) - 17'd1;
    return m[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/tifs_fifo.sv
module tifs_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   CNT_MAX = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_MAX);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PTR_MAX) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PTR_MAX) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tifs_sclk_div.sv
module tifs_sclk_div (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic [15:0] half_len,
  output logic        tick
);
  logic [15:0] cnt_q;

  assign tick = run && (cnt_q == half_len - 16'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 16'd1;
  end
endmodule

// File: rtl/tifs_master.sv
module tifs_master
  import tifs_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [3:0]        cfg_len_m1,
  input  logic [7:0]        cfg_prescale,
  input  logic [7:0]        cfg_rate,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              st_tx_empty,
  output logic              st_tx_not_full,
  output logic              st_rx_not_empty,
  output logic              st_rx_full,
  output logic              st_busy,
  output logic              sclk,
  output logic              fsync,
  output logic              dx,
  output logic              dx_oe,
  input  logic              dr
);
  tifs_state_e       state_q;
  logic              sclk_q, fs_q, oe_q, nxt_v_q;
  logic [3:0]        bit_q, lm1;
  logic [WORD_W-1:0] tx_sh_q, nxt_q, rx_sh_q, tx_head, rx_word;
  logic [15:0]       half_len;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              tick, rise_tick, fall_tick, in_frame;
  logic              frame_start, take_next, frame_done, tx_pop, dx_bit;

  assign lm1         = eff_len_m1(cfg_len_m1);
  assign half_len    = half_period(cfg_prescale, cfg_rate);
  assign in_frame    = (state_q != ST_IDLE);
  assign rise_tick   = tick && !sclk_q;
  assign fall_tick   = tick && sclk_q;
  assign frame_start = !in_frame && enable && !tx_empty;
  assign take_next   = rise_tick && (state_q == ST_DATA) && (bit_q == lm1 - 4'd1)
                       && enable && !tx_empty;
  assign frame_done  = rise_tick && (state_q == ST_DATA) && (bit_q == lm1);
  assign tx_pop      = frame_start || take_next;
  assign rx_word     = rx_sh_q & word_mask(lm1);
  assign dx_bit      = tx_sh_q[lm1];

  tifs_sclk_div u_div (
    .clk(clk), .rst_n(rst_n), .run(in_frame), .half_len(half_len), .tick(tick)
  );

  tifs_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .wdata(wr_data), .pop(tx_pop),
    .head(tx_head), .empty(tx_empty), .full(tx_full)
  );

  tifs_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(frame_done), .wdata(rx_word), .pop(rd_en),
    .head(rd_data), .empty(rx_empty), .full(rx_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      fs_q    <= 1'b0;
      oe_q    <= 1'b0;
      nxt_v_q <= 1'b0;
      bit_q   <= '0;
      tx_sh_q <= '0;
      nxt_q   <= '0;
      rx_sh_q <= '0;
    end else if (frame_start) begin
      state_q <= ST_SYNC;
      sclk_q  <= 1'b1;
      fs_q    <= 1'b1;
      tx_sh_q <= tx_head;
    end else if (fall_tick) begin
      sclk_q <= 1'b0;
      if (state_q == ST_DATA) rx_sh_q <= {rx_sh_q[WORD_W-2:0], dr};
    end else if (rise_tick) begin
      if (state_q == ST_SYNC) begin
        state_q <= ST_DATA;
        sclk_q  <= 1'b1;
        fs_q    <= 1'b0;
        oe_q    <= 1'b1;
        bit_q   <= '0;
      end else if (!frame_done) begin
        sclk_q  <= 1'b1;
        bit_q   <= bit_q + 4'd1;
        tx_sh_q <= tx_sh_q << 1;
        if (take_next) begin
          fs_q    <= 1'b1;
          nxt_v_q <= 1'b1;
          nxt_q   <= tx_head;
        end
      end else if (nxt_v_q) begin
        sclk_q  <= 1'b1;
        fs_q    <= 1'b0;
        nxt_v_q <= 1'b0;
        bit_q   <= '0;
        tx_sh_q <= nxt_q;
      end else begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end
    end
  end

  assign sclk            = sclk_q;
  assign fsync           = fs_q;
  assign dx_oe           = oe_q;
  assign dx              = oe_q ? dx_bit : 1'bz;
  assign st_tx_empty     = tx_empty;
  assign st_tx_not_full  = !tx_full;
  assign st_rx_not_empty = !rx_empty;
  assign st_rx_full      = rx_full;
  assign st_busy         = in_frame;
endmodule

// File: rtl/tifs_master_chk.sv
module tifs_master_chk (
  input logic clk,
  input logic rst_n,
  input logic in_frame,
  input logic sclk,
  input logic fsync,
  input logic dx_oe,
  input logic dx_bit,
  input logic rise_tick,
  input logic frame_start,
  input logic wr_en,
  input logic rd_en,
  input logic st_tx_empty,
  input logic st_rx_full
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |-> (!sclk && !fsync && !dx_oe));

  p_fs_with_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> $rose(sclk));

  p_fs_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsync) |-> $past(rise_tick || frame_start));

  p_dx_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_oe && $past(dx_oe) && !$stable(dx_bit)) |-> $past(rise_tick));

  p_tx_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && st_tx_empty) |=> !st_tx_empty);

  p_rx_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rx_full && !rd_en) |=> st_rx_full);
endmodule

bind tifs_master tifs_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .sclk(sclk), .fsync(fsync),
  .dx_oe(dx_oe), .dx_bit(dx_bit), .rise_tick(rise_tick), .frame_start(frame_start),
  .wr_en(wr_en), .rd_en(rd_en), .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full)
);

// File: tb/tb_tifs_master.sv
module tb_tifs_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [3:0]  cfg_len_m1 = 4'd7;
  logic [7:0]  cfg_prescale = 8'd2;
  logic [7:0]  cfg_rate = 8'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        st_tx_empty, st_tx_not_full, st_rx_not_empty, st_rx_full, st_busy;
  logic        sclk, fsync, dx, dx_oe;
  logic        dr = 1'b0;

  always #4 clk = ~clk;

  tifs_master dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_len_m1(cfg_len_m1),
    .cfg_prescale(cfg_prescale), .cfg_rate(cfg_rate), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .st_tx_empty(st_tx_empty),
    .st_tx_not_full(st_tx_not_full), .st_rx_not_empty(st_rx_not_empty),
    .st_rx_full(st_rx_full), .st_busy(st_busy), .sclk(sclk), .fsync(fsync),
    .dx(dx), .dx_oe(dx_oe), .dr(dr)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int b_len(input int lm1);
    return (lm1 < 3) ? 4 : lm1 + 1;
  endfunction
  function automatic int b_mask(input int lm1);
    return (1 << b_len(lm1)) - 1;
  endfunction
  function automatic int b_period(input int pre, input int rate);
    int p;
    p = pre - (pre % 2);
    if (p == 0) p = 2;
    return p * (rate + 1);
  endfunction

  // Slave model and line monitor, evaluated away from the active edge.
  logic [15:0] slave_words [32];
  logic [15:0] mon_words [32];
  logic [15:0] cur_sw = '0;
  logic [15:0] m_word = '0;
  logic        prev_sclk = 1'b0, fs_prev = 1'b0, s_act = 1'b0;
  int s_bit = 0, m_cnt = 0, mon_n = 0, sw_rd = 0, sw_wr = 0;
  int fs_cycles = 0, act_cycles = 0, exp_lm1 = 7;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fsync) fs_cycles++;
      if (fsync || dx_oe) act_cycles++;
      if (sclk && !prev_sclk) begin
        if (fs_prev) begin
          s_act  = 1'b1;
          s_bit  = b_len(exp_lm1) - 1;
          cur_sw = slave_words[sw_rd];
          sw_rd++;
          dr     = cur_sw[s_bit];
          m_word = '0;
          m_cnt  = 0;
        end else if (s_act) begin
          if (s_bit == 0) s_act = 1'b0;
          else begin
            s_bit--;
            dr = cur_sw[s_bit];
          end
        end
        fs_prev = fsync;
      end
      if (!sclk && prev_sclk && s_act) begin
        m_word = {m_word[14:0], dx};
        m_cnt++;
        if (m_cnt == b_len(exp_lm1)) begin
          mon_words[mon_n] = m_word;
          mon_n++;
        end
      end
      prev_sclk = sclk;
    end
  end

  task automatic configure(input int lm1, input int pre, input int rate);
    @(negedge clk);
    cfg_len_m1   = 4'(lm1);
    cfg_prescale = 8'(pre);
    cfg_rate     = 8'(rate);
    exp_lm1      = lm1;
  endtask

  task automatic push_word(input logic [15:0] w, input logic [15:0] sw);
    slave_words[sw_wr] = sw;
    sw_wr++;
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (st_busy || (enable && !st_tx_empty));
    repeat (2) @(negedge clk);
  endtask

  task automatic pop_rx();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // len_m1, prescale, rate, tx word, slave word
  localparam logic [51:0] VEC [6] = '{
    {4'd7,  8'd2, 8'd0, 16'h00A5, 16'h003C},
    {4'd15, 8'd2, 8'd1, 16'hC3A1, 16'h5E0F},
    {4'd3,  8'd4, 8'd2, 16'hFFF9, 16'hFFF6},
    {4'd11, 8'd6, 8'd0, 16'h0ABC, 16'h0123},
    {4'd0,  8'd2, 8'd0, 16'h000D, 16'h000B},
    {4'd15, 8'd3, 8'd0, 16'h8001, 16'h7FFE}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "sclk", int'(sclk), 0);
    chk("R10", "fsync", int'(fsync), 0);
    chk("R10", "dx_oe", int'(dx_oe), 0);
    chk("R10", "tx_empty", int'(st_tx_empty), 1);
    chk("R10", "tx_not_full", int'(st_tx_not_full), 1);
    chk("R10", "rx_not_empty", int'(st_rx_not_empty), 0);
    chk("R10", "busy", int'(st_busy), 0);
    enable = 1'b1;

    // Table of single frames: R2 R3 R4 R5
    foreach (VEC[i]) begin
      int lm1, pre, rate, per, n0;
      lm1  = int'(VEC[i][51:48]);
      pre  = int'(VEC[i][47:40]);
      rate = int'(VEC[i][39:32]);
      configure(lm1, pre, rate);
      per = b_period(pre, rate);
      n0  = mon_n;
      fs_cycles  = 0;
      act_cycles = 0;
      push_word(VEC[i][31:16], VEC[i][15:0]);
      wait_idle();
      chk("R3", "frames seen", mon_n - n0, 1);
      chk("R3", "dx word", int'(mon_words[n0]), int'(VEC[i][31:16]) & b_mask(lm1));
      chk("R4", "rx word", int'(rd_data), int'(VEC[i][15:0]) & b_mask(lm1));
      chk("R2", "fsync width", fs_cycles, per);
      chk("R5", "frame span", act_cycles, per * (1 + b_len(lm1)));
      chk("R1", "idle pins", int'({sclk, fsync, dx_oe}), 0);
      pop_rx();
    end

    // R6: three words back to back, no gap
    configure(7, 2, 0);
    begin
      int n0;
      n0 = mon_n;
      fs_cycles  = 0;
      act_cycles = 0;
      push_word(16'h0011, 16'h0081);
      push_word(16'h0022, 16'h0042);
      push_word(16'h0033, 16'h0024);
      wait_idle();
      chk("R6", "span no gap", act_cycles, 2 * (1 + 24));
      chk("R6", "strobe total", fs_cycles, 3 * 2);
      chk("R6", "dx word 2", int'(mon_words[n0 + 1]), 16'h0022);
      chk("R6", "dx word 3", int'(mon_words[n0 + 2]), 16'h0033);
      chk("R6", "rx first", int'(rd_data), 16'h0081);
      pop_rx();
      chk("R6", "rx second", int'(rd_data), 16'h0042);
      pop_rx();
      chk("R6", "rx third", int'(rd_data), 16'h0024);
      pop_rx();
    end

    // R9 + R7: hold off, overfill the transmit queue
    enable = 1'b0;
    begin
      int n0;
      n0 = mon_n;
      for (int k = 0; k < 9; k++) push_word(16'(16'h0040 + k), 16'(16'h0070 + k));
      repeat (20) @(negedge clk);
      chk("R9", "no frame while disabled", int'(st_busy) + int'(fsync) + int'(sclk), 0);
      chk("R7", "tx_not_full after 9 writes", int'(st_tx_not_full), 0);
      enable = 1'b1;
      wait_idle();
      chk("R7", "frames from full queue", mon_n - n0, 8);
      chk("R7", "last sent word", int'(mon_words[n0 + 7]), 16'h0047);
      chk("R8", "rx_full", int'(st_rx_full), 1);
      // slave table entry 9 of this burst was never used; skip it
      sw_wr = sw_rd;
      // R8: frame arriving while receive queue is full is discarded
      push_word(16'h00EE, 16'h00DD);
      wait_idle();
      chk("R8", "head kept", int'(rd_data), 16'h0070);
      for (int k = 0; k < 8; k++) begin
        chk("R8", "rx drain", int'(rd_data), 16'h0070 + k);
        pop_rx();
      end
      chk("R8", "overflow word dropped", int'(st_rx_not_empty), 0);
      chk("R1", "idle after bursts", int'({sclk, fsync, dx_oe}), 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule